// File: doc/BRIEF.md
# Dual-Channel Master Serial Output Controller

This block sends two 16-bit conversion results to a host as one 32-bit serial frame and acts as the clock master for that link. It drives the serial clock, the serial data line and a frame-valid strobe itself. It also drives a busy flag that covers a conversion phase of fixed length; the analog conversion is not part of the block and is modelled only by that phase. When the phase ends, both channel words are copied into a holding register.

There are two read modes, picked when a conversion starts. In read-after-convert mode, the frame carrying the new result follows the conversion, and busy stays high until the last bit has left. In this mode a two-bit divider setting slows the serial clock for slow hosts. In read-during-convert mode, the frame carries the result held from the previous conversion and is sent while the new conversion runs, at the fastest clock rate. The strobe drops between the two channel words. A channel-order input picks which word goes first. The clock pin and the strobe pin can each be inverted.

Top module: `dual_serial_master`

## Requirements
- R1: A frame carries exactly 32 data bits, most significant bit first. Each bit is presented for one active serial clock pulse, and there are exactly 32 such pulses per frame.
- R2: With `order_a_first` = 1, frame bits 31..16 are `ch_a` and bits 15..0 are `ch_b`. With `order_a_first` = 0, the two words swap places.
- R3: The serial clock half-period is measured in system clocks. In read-after-convert mode it is 2 << `div_sel`, which gives 2, 4, 8 or 16. In read-during-convert mode it is always 2, whatever `div_sel` holds.
- R4: The internal clock idles low and its rising edge is the sampling edge. `sdout` changes only after an internal falling edge and holds steady while the internal clock is high.
- R5: The `sclk` pin equals the internal clock XOR `inv_sclk`. The `sync` pin equals the internal strobe XOR `inv_sync`. The internal strobe is high while frame data is valid.
- R6: While no frame is running, `sdout` is 0, `sclk` equals `inv_sclk` and `sync` equals `inv_sync`. After reset, `busy` is 0.
- R7: In read-after-convert mode (`read_during` = 0 when `conv_start` is accepted), `busy` is high for CONV_CYCLES + 1 + 64 × half-period cycles. The frame carries the words present when the conversion ends.
- R8: In read-during-convert mode (`read_during` = 1), `busy` is high for exactly CONV_CYCLES cycles. A frame of the previously held result starts with the conversion. The first conversion after reset sends no frame.
- R9: In read-during-convert mode, the internal strobe goes low for one half-period after bit 16 of the frame (the first channel's LSB) and goes low again after the last bit. In read-after-convert mode it stays high throughout the frame.
- R10: A `conv_start` pulse while `busy` is high is ignored. It neither extends `busy` nor adds a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| conv_start | input | 1 | One-cycle pulse that starts a conversion phase |
| ch_a | input | 16 | Channel A conversion word |
| ch_b | input | 16 | Channel B conversion word |
| order_a_first | input | 1 | 1: channel A is sent first; 0: channel B is sent first |
| inv_sclk | input | 1 | Inverts the serial clock pin |
| inv_sync | input | 1 | Inverts the strobe pin |
| div_sel | input | 2 | Clock divider setting for read-after-convert mode |
| read_during | input | 1 | 1: read the previous result during conversion; 0: read after conversion |
| sclk | output | 1 | Serial clock |
| sdout | output | 1 | Serial data |
| sync | output | 1 | Frame-valid strobe |
| busy | output | 1 | Conversion (and, in read-after mode, frame) in progress |

## Verification
The assertions check the following on every cycle:
- data stays steady while the internal clock is high;
- the serial pins sit at their idle levels between frames;
- a frame never starts while one is still running;
- the strobe falls mid-frame only into the inter-channel gap;
- busy rises only after a start request;
- in read-after mode, busy covers the whole frame.

Some properties need whole-frame observation, so only the directed scenarios can show them: the bit content and channel order, the half-period chosen by each divider setting, the exact busy lengths, the carry-over of the previous result in read-during mode, and the dropped start request.

// File: rtl/sms_pkg.sv
// Shared types and helpers for the dual-channel master serial controller.
// Assumes: a frame is two equal-width channel words.
package sms_pkg;
    typedef enum logic [1:0] {
        SH_IDLE = 2'd0,
        SH_LOW  = 2'd1,
        SH_HIGH = 2'd2,
        SH_GAP  = 2'd3
    } shift_state_t;
endpackage

// File: rtl/sms_conv_timer.sv
// Models the fixed-length conversion phase and the result holding register.
// Assumes: start is only raised when the phase is not running (the top gates it).
module sms_conv_timer #(
    parameter int CONV_CYCLES = 160,
    parameter int WORD_W      = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [WORD_W-1:0] ch_a,
    input  logic [WORD_W-1:0] ch_b,
    output logic              running,
    output logic              conv_end,
    output logic [WORD_W-1:0] hold_a,
    output logic [WORD_W-1:0] hold_b,
    output logic              hold_valid
);
    localparam int CNT_W = $clog2(CONV_CYCLES + 1);

    logic [CNT_W-1:0] cnt_q;

    assign conv_end = running && (cnt_q == '0);

    // Count the conversion phase down and capture both words at its end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running    <= 1'b0;
            cnt_q      <= '0;
            hold_a     <= '0;
            hold_b     <= '0;
            hold_valid <= 1'b0;
        end else if (start) begin
            running <= 1'b1;
            cnt_q   <= CNT_W'(CONV_CYCLES - 1);
        end else if (conv_end) begin
            running    <= 1'b0;
            hold_a     <= ch_a;
            hold_b     <= ch_b;
            hold_valid <= 1'b1;
        end else if (running) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // R8
    hold_only_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold_valid) |-> $past(running));
endmodule

// File: rtl/sms_frame_shifter.sv
// Shifts one frame out MSB first with a generated serial clock and strobe.
// Assumes: load is never raised while a frame is running; half_len >= 1.
module sms_frame_shifter
    import sms_pkg::*;
#(
    parameter int FRAME_W = 32,
    parameter int HALF_W  = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [FRAME_W-1:0] load_word,
    input  logic [HALF_W-1:0]  half_len,
    input  logic               gap_en,
    output logic               sclk_int,
    output logic               sync_int,
    output logic               sdout_int,
    output logic               active,
    output logic               done
);
    localparam int BIT_W = $clog2(FRAME_W);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(FRAME_W - 1);
    localparam logic [BIT_W-1:0] MID_BIT  = BIT_W'(FRAME_W / 2 - 1);

    shift_state_t       state_q;
    logic [FRAME_W-1:0] shreg_q;
    logic [HALF_W-1:0]  timer_q;
    logic [HALF_W-1:0]  half_q;
    logic [BIT_W-1:0]   bit_q;
    logic               gap_q;

    assign active    = (state_q != SH_IDLE);
    assign sclk_int  = (state_q == SH_HIGH);
    assign sync_int  = active && (state_q != SH_GAP);
    assign sdout_int = active ? shreg_q[FRAME_W-1] : 1'b0;
    assign done      = (state_q == SH_HIGH) && (timer_q == '0) && (bit_q == LAST_BIT);

    // Step through low/high half-periods, shifting after each falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SH_IDLE;
            shreg_q <= '0;
            timer_q <= '0;
            half_q  <= '0;
            bit_q   <= '0;
            gap_q   <= 1'b0;
        end else if (load) begin
            state_q <= SH_LOW;
            shreg_q <= load_word;
            timer_q <= half_len - 1'b1;
            half_q  <= half_len;
            bit_q   <= '0;
            gap_q   <= gap_en;
        end else if (active) begin
            if (timer_q != '0) begin
                timer_q <= timer_q - 1'b1;
            end else begin
                timer_q <= half_q - 1'b1;
                unique case (state_q)
                    SH_LOW:  state_q <= SH_HIGH;
                    SH_GAP:  state_q <= SH_LOW;
                    SH_HIGH: begin
                        if (bit_q == LAST_BIT) begin
                            state_q <= SH_IDLE;
                        end else begin
                            shreg_q <= {shreg_q[FRAME_W-2:0], 1'b0};
                            bit_q   <= bit_q + 1'b1;
                            state_q <= (gap_q && bit_q == MID_BIT) ? SH_GAP : SH_LOW;
                        end
                    end
                    default: state_q <= SH_IDLE;
                endcase
            end
        end
    end

    // R4
    data_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_int && $past(sclk_int)) |-> $stable(sdout_int));

    // R1
    no_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !active);

    // R9
    gap_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(sync_int) && active) |-> (gap_q && bit_q == MID_BIT + 1'b1));
endmodule

// File: rtl/dual_serial_master.sv
// Top: conversion phase, read-mode sequencing, channel ordering and pin polarity.
// Assumes: CONV_CYCLES >= 64*2 + 2, so a read-during frame ends before busy drops.
module dual_serial_master #(
    parameter int WORD_W      = 16,
    parameter int CONV_CYCLES = 160
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              conv_start,
    input  logic [WORD_W-1:0] ch_a,
    input  logic [WORD_W-1:0] ch_b,
    input  logic              order_a_first,
    input  logic              inv_sclk,
    input  logic              inv_sync,
    input  logic [1:0]        div_sel,
    input  logic              read_during,
    output logic              sclk,
    output logic              sdout,
    output logic              sync,
    output logic              busy
);
    localparam int FRAME_W = 2 * WORD_W;
    localparam int HALF_W  = 5;
    localparam logic [HALF_W-1:0] FAST_HALF = HALF_W'(2);

    logic              busy_q, mode_q, rac_load_q;
    logic              accept, rdc_load, frame_load;
    logic              conv_run, conv_end, hold_valid;
    logic [WORD_W-1:0] hold_a, hold_b;
    logic [FRAME_W-1:0] frame_word;
    logic [HALF_W-1:0] half_len;
    logic              sclk_int, sync_int, sdout_int, frame_active, frame_done;

    assign accept     = conv_start && !busy_q;
    assign rdc_load   = accept && read_during && hold_valid;
    assign frame_load = rdc_load || rac_load_q;
    assign frame_word = order_a_first ? {hold_a, hold_b} : {hold_b, hold_a};
    assign half_len   = rdc_load ? FAST_HALF : (FAST_HALF << div_sel);

    sms_conv_timer #(
        .CONV_CYCLES(CONV_CYCLES),
        .WORD_W     (WORD_W)
    ) u_conv (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (accept),
        .ch_a      (ch_a),
        .ch_b      (ch_b),
        .running   (conv_run),
        .conv_end  (conv_end),
        .hold_a    (hold_a),
        .hold_b    (hold_b),
        .hold_valid(hold_valid)
    );

    sms_frame_shifter #(
        .FRAME_W(FRAME_W),
        .HALF_W (HALF_W)
    ) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (frame_load),
        .load_word(frame_word),
        .half_len (half_len),
        .gap_en   (rdc_load),
        .sclk_int (sclk_int),
        .sync_int (sync_int),
        .sdout_int(sdout_int),
        .active   (frame_active),
        .done     (frame_done)
    );

    // Track busy, the latched read mode and the delayed read-after load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q     <= 1'b0;
            mode_q     <= 1'b0;
            rac_load_q <= 1'b0;
        end else begin
            rac_load_q <= conv_end && !mode_q;
            if (accept) begin
                busy_q <= 1'b1;
                mode_q <= read_during;
            end else if (conv_end && mode_q) begin
                busy_q <= 1'b0;
            end else if (frame_done && !mode_q) begin
                busy_q <= 1'b0;
            end
        end
    end

    assign sclk  = sclk_int ^ inv_sclk;
    assign sync  = sync_int ^ inv_sync;
    assign sdout = sdout_int;
    assign busy  = busy_q;

    // R6
    idle_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_active |-> (!sdout && sclk == inv_sclk && sync == inv_sync));

    // R7
    rac_busy_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_active && !mode_q) |-> busy);

    // R10
    busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(conv_start));

    // R8
    rdc_busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && mode_q) |-> $past(conv_run));
endmodule

// File: tb/dual_serial_master_tb.sv
module dual_serial_master_tb;
    localparam int CONV = 160;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        conv_start = 1'b0;
    logic [15:0] ch_a = '0, ch_b = '0;
    logic        order_a_first = 1'b1, inv_sclk = 1'b0, inv_sync = 1'b0;
    logic [1:0]  div_sel = 2'd0;
    logic        read_during = 1'b0;
    logic        sclk, sdout, sync, busy;

    int checks = 0, fails = 0;

    // Results of one observed conversion.
    logic [31:0] got_bits;
    int          nbits, busy_len, interval, gap_low, unsteady;

    dual_serial_master #(.WORD_W(16), .CONV_CYCLES(CONV)) u_dut (
        .clk(clk), .rst_n(rst_n), .conv_start(conv_start), .ch_a(ch_a), .ch_b(ch_b),
        .order_a_first(order_a_first), .inv_sclk(inv_sclk), .inv_sync(inv_sync),
        .div_sel(div_sel), .read_during(read_during),
        .sclk(sclk), .sdout(sdout), .sync(sync), .busy(busy)
    );

    always #4 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Pulse conv_start and watch the pins until busy has fallen.
    task automatic observe(input bit extra_start);
        logic prev_clk, prev_dat, cur_clk;
        int   idx, first_rise;
        got_bits = '0; nbits = 0; busy_len = 0; interval = 0;
        gap_low = 0; unsteady = 0; first_rise = -1; idx = 0;
        @(negedge clk); conv_start = 1'b1;
        @(negedge clk); conv_start = 1'b0;
        prev_clk = 1'b0; prev_dat = 1'b0;
        for (int s = 0; s < 2000; s++) begin
            cur_clk = sclk ^ inv_sclk;
            if (busy) busy_len++;
            if (cur_clk && !prev_clk) begin
                if (nbits < 32) got_bits = {got_bits[30:0], sdout};
                nbits++;
                if (nbits == 1) first_rise = idx;
                if (nbits == 2) interval = idx - first_rise;
            end
            if (cur_clk && prev_clk && sdout !== prev_dat) unsteady++;
            if (nbits >= 1 && nbits < 32 && (sync ^ inv_sync) == 1'b0) gap_low++;
            prev_clk = cur_clk; prev_dat = sdout; idx++;
            if (extra_start && s == 20) conv_start = 1'b1;
            if (extra_start && s == 21) conv_start = 1'b0;
            if (!busy && s > 2 && (sclk ^ inv_sclk) == 1'b0 && (sync ^ inv_sync) == 1'b0) break;
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        do_reset();
        @(negedge clk);
        check("R6 reset sdout", {31'd0, sdout}, 32'd0);
        check("R6 reset sclk", {31'd0, sclk}, {31'd0, inv_sclk});
        check("R6 reset sync", {31'd0, sync}, {31'd0, inv_sync});
        check("R6 reset busy", {31'd0, busy}, 32'd0);
    endtask

    task automatic t_rac(input logic [15:0] a, input logic [15:0] b, input logic ord,
                         input logic [1:0] dv, input logic isc, input logic isy);
        int h;
        h = 2 << dv;
        ch_a = a; ch_b = b; order_a_first = ord; div_sel = dv;
        inv_sclk = isc; inv_sync = isy; read_during = 1'b0;
        observe(1'b0);
        check("R1 bit count", nbits, 32);
        check("R2 frame content", got_bits, ord ? {a, b} : {b, a});
        check("R3 half period", interval, 2 * h);
        check("R4 steady data", unsteady, 0);
        check("R9 no gap in read-after", gap_low, 0);
        check("R7 busy length", busy_len, CONV + 1 + 64 * h);
        repeat (3) @(negedge clk);
        check("R5 R6 idle sclk", {31'd0, sclk}, {31'd0, isc});
        check("R5 R6 idle sync", {31'd0, sync}, {31'd0, isy});
        check("R6 idle sdout", {31'd0, sdout}, 32'd0);
    endtask

    task automatic t_rdc();
        do_reset();
        ch_a = 16'h1357; ch_b = 16'hFACE; order_a_first = 1'b1;
        div_sel = 2'd3; read_during = 1'b1; inv_sclk = 1'b0; inv_sync = 1'b0;
        observe(1'b0);
        check("R8 no frame after reset", nbits, 0);
        check("R8 busy length first", busy_len, CONV);
        ch_a = 16'h0F0F; ch_b = 16'h8001;
        observe(1'b0);
        check("R8 previous result sent", got_bits, {16'h1357, 16'hFACE});
        check("R1 bit count rdc", nbits, 32);
        check("R3 fast half period in rdc", interval, 4);
        check("R9 sync gap", gap_low, 2);
        check("R8 busy length", busy_len, CONV);
    endtask

    task automatic t_ignore();
        do_reset();
        ch_a = 16'h00FF; ch_b = 16'hA5A5; order_a_first = 1'b0; div_sel = 2'd0;
        read_during = 1'b0; inv_sclk = 1'b0; inv_sync = 1'b0;
        observe(1'b1);
        check("R10 busy not extended", busy_len, CONV + 1 + 128);
        check("R10 single frame", nbits, 32);
        repeat (400) @(negedge clk);
        check("R10 no late busy", {31'd0, busy}, 32'd0);
    endtask

    initial begin
        t_reset();
        t_rac(16'hA5C3, 16'h3C5A, 1'b1, 2'd0, 1'b0, 1'b0);
        t_rac(16'h8001, 16'h7FFE, 1'b0, 2'd3, 1'b0, 1'b0);
        t_rac(16'hDEAD, 16'hBEEF, 1'b1, 2'd1, 1'b1, 1'b1);
        t_rac(16'h1234, 16'hFFFF, 1'b0, 2'd2, 1'b1, 1'b0);
        t_rdc();
        t_ignore();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #2_000_000;
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule